// File: doc/BRIEF.md
# Multichannel TDM Audio Serial Transmitter

This block sends the samples of a multichannel converter out of the chip as serial audio. It runs as a slave. An outside master drives the bit clock and the frame sync, and this block only follows them. A load strobe writes one 24-bit word per channel into a staging register. The block moves that staged set into a frame register when a frame begins, and shifts the frame register out MSB first, changing its data lines after each bit-clock fall.

Two formats are available, chosen at the start of each frame.

In TDM, one line carries every channel in one frame. Channel c sits in slot c, and each slot is a fixed number of bit clocks wide. The sample starts the slot, and zeros fill the rest of it.

In the two-channel left-justified format, the block drives one line per channel pair. The high half of the frame sync period sends the lower channel of each pair. The low half sends the upper channel.

The frame length is not fixed. A long frame or half sends zeros after the data. A short one stops where the next edge arrives, and the next frame or half starts again at the MSB.

All inputs are taken as synchronous to `clk`, which must run much faster than the bit clock. The block finds the bit-clock edges by sampling `sclk` on `clk`.

Top module: `tdm_audio_tx`

## Requirements
- R1: After reset, and until the first frame start, every `sdout` line is 0. A frame start is a sampled `fs` going from 0 to 1, seen at a detected `sclk` rising edge.
- R2: In TDM (`fmt_sel`=1), the bit clock at which the frame start is seen is position 0. Position k goes out on `sdout[0]`. It belongs to slot k / SLOT_W and bit k % SLOT_W. Bit b of slot c is bit SAMPLE_W-1-b of channel c, so the MSB goes first. Channel c occupies `samples[c*SAMPLE_W +: SAMPLE_W]`.
- R3: In TDM, a slot bit b >= SAMPLE_W is 0. Every position at or beyond NUM_CH*SLOT_W is also 0, including very long frames where the position count saturates.
- R4: In TDM, a new frame start that comes before the frame is complete ends it at once. The new frame starts again at position 0 of slot 0.
- R5: While a TDM frame is running, every `sdout` line except line 0 is 0.
- R6: In left-justified mode (`fmt_sel`=0), the frame starts at the rising edge of `fs`. Line p sends channel 2p, MSB first, from the first bit clock. When a falling `fs` is seen at an `sclk` rise, a second half begins, and line p sends channel 2p+1 from its MSB.
- R7: In left-justified mode, positions at or beyond SAMPLE_W in a half are 0.
- R8: In left-justified mode, a half shorter than SAMPLE_W sends only the bits it has clocks for. The next half starts again at the MSB.
- R9: `sdout` changes only just after a falling edge of `sclk`. It holds steady through the high phase, where the receiver samples it.
- R10: The staged samples are copied into the frame register at each frame start. A load during a frame has no effect on that frame and takes effect at the next one. A load in the same `clk` cycle as a frame start is used by that frame.
- R11: `fmt_sel` is sampled only at a frame start. A change during a frame leaves that frame's format as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it samples `sclk` and `fs` |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Writes `samples` into the staging register |
| samples | input | NUM_CH*SAMPLE_W | Channel words; channel c at `[c*SAMPLE_W +: SAMPLE_W]` |
| sclk | input | 1 | Bit clock from the master |
| fs | input | 1 | Frame sync (TDM) or left/right clock (left-justified) |
| fmt_sel | input | 1 | 1 = TDM, 0 = left-justified; sampled at frame start |
| sdout | output | NUM_CH/2 | Serial data lines; TDM uses line 0 only |

## Verification
The bench builds the block with NUM_CH=4, SAMPLE_W=6 and SLOT_W=8, so a nominal TDM frame is 32 positions and the position counter saturates at 63. With these sizes a frame of 70 bit clocks runs the counter into saturation, and every data bit, pad bit and slot boundary of every channel is checked against an expected value computed arithmetically. Both halves of the left-justified format are short enough to check too, at lengths below, equal to and above the sample width. The sweeps vary the sample patterns and cover loads during a frame, a load in the same cycle as a frame start, and format changes during a frame.

// File: rtl/atx_pkg.sv
package atx_pkg;

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_TDM = 1'b1
    } atx_fmt_e;

    // Events seen on a bit-clock rising edge
    typedef struct packed {
        logic frame_start;
        logic half_start;
    } atx_evt_t;

    // State that holds for the frame in progress
    typedef struct packed {
        logic     active;
        atx_fmt_e fmt;
        logic     second_half;
    } atx_frame_state_t;

    // Width of the bit-position counter: one more bit than a full TDM frame needs
    function automatic int unsigned pos_width(input int unsigned nch, input int unsigned slot_w);
        return $clog2(nch * slot_w) + 1;
    endfunction

    // Number of serial lines: one per channel pair
    function automatic int unsigned line_count(input int unsigned nch);
        return (nch + 1) / 2;
    endfunction

endpackage

// File: rtl/atx_edge_det.sv
module atx_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig,
    output logic rise,
    output logic fall
);
    logic sig_q;

    always_ff @(posedge clk) begin
        if (rst) sig_q <= 1'b0;
        else     sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
    assign fall = ~sig & sig_q;
endmodule

// File: rtl/atx_frame_ctl.sv
module atx_frame_ctl
    import atx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_rise,
    input  logic             fs,
    input  atx_fmt_e         fmt_sel,
    output atx_evt_t         evt,
    output atx_frame_state_t st
);
    logic fs_q;

    always_comb begin
        evt.frame_start = sclk_rise & fs & ~fs_q;
        evt.half_start  = sclk_rise & st.active & (st.fmt == FMT_LJ) & ~fs & fs_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q           <= 1'b0;
            st.active      <= 1'b0;
            st.fmt         <= FMT_LJ;
            st.second_half <= 1'b0;
        end else if (sclk_rise) begin
            fs_q <= fs;
            if (evt.frame_start) begin
                st.active      <= 1'b1;
                st.fmt         <= fmt_sel;
                st.second_half <= 1'b0;
            end else if (evt.half_start) begin
                st.second_half <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/atx_sample_bank.sv
module atx_sample_bank #(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 24,
    localparam int unsigned TOTAL_W = NUM_CH * SAMPLE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [TOTAL_W-1:0] samples_in,
    input  logic               capture,
    output logic [TOTAL_W-1:0] shadow
);
    logic [TOTAL_W-1:0] staging;

    always_ff @(posedge clk) begin
        if (rst) begin
            staging <= '0;
            shadow  <= '0;
        end else begin
            if (load)    staging <= samples_in;
            if (capture) shadow  <= load ? samples_in : staging;
        end
    end
endmodule

// File: rtl/atx_serializer.sv
module atx_serializer
    import atx_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned SLOT_W   = 32,
    localparam int unsigned NUM_LINES = line_count(NUM_CH),
    localparam int unsigned POS_W     = pos_width(NUM_CH, SLOT_W),
    localparam int unsigned TOTAL_W   = NUM_CH * SAMPLE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_fall,
    input  logic                 restart,
    input  atx_frame_state_t     st,
    input  logic [TOTAL_W-1:0]   shadow,
    output logic [NUM_LINES-1:0] sdout
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [SAMPLE_W-1:0]  words [NUM_CH];
    logic [POS_W-1:0]     pos, pos_next;
    logic                 restart_pend;
    logic                 tdm_bit;
    logic [NUM_LINES-1:0] lj_bits;
    logic [NUM_LINES-1:0] line_next;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_unpack
        assign words[c] = shadow[c*SAMPLE_W +: SAMPLE_W];
    end

    // MSB-first bit idx of a word; idx past the word gives 0
    function automatic logic msb_bit(input logic [SAMPLE_W-1:0] w, input int unsigned idx);
        logic r;
        r = 1'b0;
        for (int unsigned b = 0; b < SAMPLE_W; b++) begin
            if (idx == b) r = w[SAMPLE_W-1-b];
        end
        return r;
    endfunction

    // Word of channel idx; idx past the last channel gives 0
    function automatic logic [SAMPLE_W-1:0] pick_word(input int unsigned idx);
        logic [SAMPLE_W-1:0] r;
        r = '0;
        for (int unsigned c = 0; c < NUM_CH; c++) begin
            if (idx == c) r = words[c];
        end
        return r;
    endfunction

    always_comb begin
        if (restart_pend)        pos_next = '0;
        else if (pos == POS_MAX) pos_next = pos;
        else                     pos_next = pos + 1'b1;
    end

    always_comb begin
        int unsigned slot_i;
        int unsigned bit_i;
        slot_i  = 32'(pos_next) / SLOT_W;
        bit_i   = 32'(pos_next) % SLOT_W;
        tdm_bit = msb_bit(pick_word(slot_i), bit_i);
    end

    for (genvar p = 0; p < NUM_LINES; p++) begin : g_line
        if (2*p + 1 < NUM_CH) begin : g_pair
            assign lj_bits[p] = msb_bit(st.second_half ? words[2*p+1] : words[2*p], 32'(pos_next));
        end else begin : g_single
            assign lj_bits[p] = st.second_half ? 1'b0 : msb_bit(words[2*p], 32'(pos_next));
        end
    end

    always_comb begin
        line_next = '0;
        if (st.active) begin
            if (st.fmt == FMT_TDM) line_next[0] = tdm_bit;
            else                   line_next    = lj_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos          <= '0;
            restart_pend <= 1'b0;
            sdout        <= '0;
        end else begin
            if (restart) restart_pend <= 1'b1;
            if (sclk_fall) begin
                restart_pend <= 1'b0;
                pos          <= pos_next;
                sdout        <= line_next;
            end
        end
    end
endmodule

// File: rtl/tdm_audio_tx.sv
module tdm_audio_tx
    import atx_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 24,
    parameter int unsigned SLOT_W   = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [NUM_CH*SAMPLE_W-1:0]   samples,
    input  logic                         sclk,
    input  logic                         fs,
    input  atx_fmt_e                     fmt_sel,
    output logic [(NUM_CH+1)/2-1:0]      sdout
);
    logic             sclk_rise, sclk_fall;
    atx_evt_t         evt;
    atx_frame_state_t st;
    logic [NUM_CH*SAMPLE_W-1:0] shadow;

    logic     frame_start;
    logic     restart;
    logic     active;
    atx_fmt_e fmt_q;

    assign frame_start = evt.frame_start;
    assign restart     = evt.frame_start | evt.half_start;
    assign active      = st.active;
    assign fmt_q       = st.fmt;

    atx_edge_det u_sclk_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (sclk),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    atx_frame_ctl u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .fs        (fs),
        .fmt_sel   (fmt_sel),
        .evt       (evt),
        .st        (st)
    );

    atx_sample_bank #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .samples_in (samples),
        .capture    (frame_start),
        .shadow     (shadow)
    );

    atx_serializer #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .sclk_fall (sclk_fall),
        .restart   (restart),
        .st        (st),
        .shadow    (shadow),
        .sdout     (sdout)
    );
endmodule

// File: rtl/atx_tx_checks.sv
module atx_tx_checks
    import atx_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 24,
    localparam int unsigned NL      = line_count(NUM_CH)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       sclk,
    input logic [NL-1:0]              sdout,
    input logic                       sclk_fall,
    input logic                       frame_start,
    input logic                       active,
    input atx_fmt_e                   fmt_q,
    input logic [NUM_CH*SAMPLE_W-1:0] shadow
);
    // R9: a change on the data lines follows a high-then-low sample of sclk
    assert_change_after_fall_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdout) |-> ($past(sclk) == 1'b0 && $past(sclk, 2) == 1'b1));

    // R1: the lines stay quiet until a frame has started
    assert_idle_before_frame_R1: assert property (@(posedge clk) disable iff (rst)
        !active |-> sdout == '0);

    // R10: the frame register moves only on a frame start
    assert_shadow_held_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(shadow));

    if (NL > 1) begin : g_upper
        // R5: a TDM frame drives line 0 only
        assert_tdm_upper_idle_R5: assert property (@(posedge clk) disable iff (rst)
            ($past(sclk_fall) && fmt_q == FMT_TDM) |-> sdout[NL-1:1] == '0);
    end
endmodule

bind tdm_audio_tx atx_tx_checks #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .sclk        (sclk),
    .sdout       (sdout),
    .sclk_fall   (sclk_fall),
    .frame_start (frame_start),
    .active      (active),
    .fmt_q       (fmt_q),
    .shadow      (shadow)
);

// File: tb/tdm_audio_tx_bench.sv
module tdm_audio_tx_bench;
    import atx_pkg::*;

    localparam int unsigned NCH = 4;
    localparam int unsigned W   = 6;
    localparam int unsigned SW  = 8;
    localparam int unsigned NL  = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst, load, sclk, fs;
    logic [NCH*W-1:0] samples;
    atx_fmt_e         fmt_sel;
    logic [NL-1:0]    sdout;

    int ntests = 0;
    int nfail  = 0;

    logic [W-1:0]  staged [NCH];
    logic [W-1:0]  cur    [NCH];
    logic [NL-1:0] last_out;

    tdm_audio_tx #(.NUM_CH(NCH), .SAMPLE_W(W), .SLOT_W(SW)) u_tdm_audio_tx (
        .clk(clk), .rst(rst), .load(load), .samples(samples),
        .sclk(sclk), .fs(fs), .fmt_sel(fmt_sel), .sdout(sdout)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        ntests++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(input int seed, input int c);
        int v;
        if (seed == 100)      v = 63;
        else if (seed == 101) v = (c % 2 == 0) ? 42 : 21;
        else                  v = (c * 11 + seed * 5 + 3) % 64;
        return v[W-1:0];
    endfunction

    function automatic logic word_bit(input logic [W-1:0] w, input int k);
        return (k < int'(W)) ? w[W-1-k] : 1'b0;
    endfunction

    function automatic logic tdm_exp(input int k);
        int slot;
        slot = k / SW;
        return (slot < int'(NCH)) ? word_bit(cur[slot], k % SW) : 1'b0;
    endfunction

    task automatic fill(input int seed);
        for (int c = 0; c < int'(NCH); c++) begin
            samples[c*W +: W] = pat(seed, c);
            staged[c] = pat(seed, c);
        end
    endtask

    task automatic load_seed(input int seed);
        fill(seed);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
    endtask

    // One bit clock; got is the value after its falling edge
    task automatic bitclk(input logic fsv, input int coload, output logic [NL-1:0] got);
        sclk = 1'b1;
        fs   = fsv;
        if (coload >= 0) begin
            fill(coload);
            load = 1'b1;
        end
        @(negedge clk);
        load = 1'b0;
        @(negedge clk);
        check("R9 lines hold through sclk high", 32'(sdout), 32'(last_out));
        sclk = 1'b0;
        @(negedge clk);
        @(negedge clk);
        got = sdout;
        last_out = got;
    endtask

    task automatic flip_fmt();
        fmt_sel = (fmt_sel == FMT_TDM) ? FMT_LJ : FMT_TDM;
    endtask

    task automatic tdm_frame(input int nclk, input int load_at, input int lseed,
                             input int flip_at, input int coload, input string req);
        logic [NL-1:0] got;
        if (coload >= 0) begin
            for (int c = 0; c < int'(NCH); c++) cur[c] = pat(coload, c);
        end else begin
            for (int c = 0; c < int'(NCH); c++) cur[c] = staged[c];
        end
        for (int k = 0; k < nclk; k++) begin
            bitclk(k == 0, (k == 0) ? coload : -1, got);
            check(req, 32'(got[0]), 32'(tdm_exp(k)));
            check("R5 upper line idle in TDM", 32'(got[NL-1:1]), 32'd0);
            if (k == load_at) load_seed(lseed);
            if (k == flip_at) flip_fmt();
        end
    endtask

    task automatic lj_frame(input int n1, input int n2, input int flip_at, input string req);
        logic [NL-1:0] got;
        for (int c = 0; c < int'(NCH); c++) cur[c] = staged[c];
        for (int k = 0; k < n1; k++) begin
            bitclk(1'b1, -1, got);
            for (int p = 0; p < int'(NL); p++)
                check(req, 32'(got[p]), 32'(word_bit(cur[2*p], k)));
            if (k == flip_at) flip_fmt();
        end
        for (int k = 0; k < n2; k++) begin
            bitclk(1'b0, -1, got);
            for (int p = 0; p < int'(NL); p++)
                check(req, 32'(got[p]), 32'(word_bit(cur[2*p+1], k)));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        ntests++;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        logic [NL-1:0] got;
        rst = 1'b1; load = 1'b0; sclk = 1'b0; fs = 1'b0;
        samples = '0; fmt_sel = FMT_TDM; last_out = '0;
        for (int c = 0; c < int'(NCH); c++) staged[c] = '0;
        repeat (4) @(negedge clk);
        check("R1 reset state", 32'(sdout), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1: bit clocks with no frame start leave the lines at zero
        load_seed(7);
        for (int k = 0; k < 5; k++) begin
            bitclk(1'b0, -1, got);
            check("R1 idle before first frame", 32'(got), 32'd0);
        end

        // R2 / R3: nominal, long and saturating TDM frames
        load_seed(1);
        tdm_frame(32, -1, 0, -1, -1, "R2 TDM nominal frame");
        load_seed(100);
        tdm_frame(40, -1, 0, -1, -1, "R3 TDM long frame zero pad");
        load_seed(2);
        tdm_frame(70, -1, 0, -1, -1, "R3 TDM saturated frame zero pad");

        // R4: a short frame is cut off and the next one restarts
        load_seed(3);
        tdm_frame(13, -1, 0, -1, -1, "R4 TDM short frame");
        tdm_frame(32, -1, 0, -1, -1, "R4 TDM restart after short frame");

        // R10: a mid-frame load waits for the next frame; a same-cycle load is used
        tdm_frame(32, 5, 4, -1, -1, "R10 load during frame ignored");
        tdm_frame(32, -1, 0, -1, -1, "R10 load applied at next frame");
        tdm_frame(32, -1, 0, -1, 5, "R10 load with frame start");

        // R11: the format flips mid-frame; this frame stays TDM, the next is LJ
        load_seed(6);
        tdm_frame(32, -1, 0, 10, -1, "R11 format held during TDM frame");
        lj_frame(8, 8, -1, "R6 LJ nominal halves");

        // R7 / R8: long and short halves
        load_seed(8);
        lj_frame(12, 12, -1, "R7 LJ long halves zero pad");
        lj_frame(3, 5, -1, "R8 LJ short halves truncated");
        lj_frame(6, 6, -1, "R8 LJ halves equal to sample width");
        load_seed(101);
        lj_frame(8, 8, 1, "R11 format held during LJ frame");

        // The flip above takes effect here
        load_seed(9);
        tdm_frame(32, -1, 0, -1, -1, "R2 TDM after LJ frames");

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule